// File: doc/BRIEF.md
# DMA Control, Mask and Status Unit

This block is the control-register side of a four-channel DMA controller together with the selector that decides which channel is serviced next. A host writes one of eight control offsets to issue commands: load the command byte, raise or drop a software request, mask or unmask one channel, store a channel's mode byte, clear the byte-pointer flip-flop, reset the controller, unmask every channel, or load all mask bits at once. Reads return a status byte or the mask. The status byte holds the terminal-count flags in bits [3:0] and the request flags in bits [7:4]. Reading the status clears only the terminal-count half.

Peripheral request lines set and drop the request flags directly. A transfer engine outside this block reports terminal count on a per-channel input. The selector grants the lowest-numbered channel that is both requesting and unmasked. It gives the transfer engine a one-hot grant, an index, and the decoded mode fields of the granted channel. The engine itself toggles the byte-pointer flip-flop through a strobe. Address and count registers live outside this block.

Top module: `dma_ctl_unit`

## Requirements
- R1: After reset the mask reads 4'hF, status is 8'h00, the command byte is 8'h00, the flip-flop is 0, every mode byte is 8'h00 and no channel is granted.
- R2: A command write (offset 0) is stored only when the data has no bit set outside bit 2 (8'h00 and 8'h04 are accepted). Any other value leaves the command byte unchanged.
- R3: A request write (offset 1) takes the channel from data[1:0]. Data bit 2 sets (1) or clears (0) status bit channel+4, and the same write clears status bit channel.
- R4: A single-mask write (offset 2) sets mask bit data[1:0] to data bit 2 and leaves the other mask bits unchanged.
- R5: Offset 6 clears all four mask bits. Offset 7 loads the mask from data[3:0].
- R6: A mode write (offset 3) stores the whole byte for channel data[1:0]. For the granted channel the unit presents the transfer type from bits [3:2], auto-init from bit 4, address decrement from bit 5 and operating mode from bits [7:6].
- R7: A master-reset write (offset 5) clears the flip-flop, the status byte and the command byte, and sets every mask bit. Mode bytes are kept.
- R8: A write to offset 4 clears the flip-flop. Otherwise each cycle with ff_toggle high inverts it. A clear in the same cycle wins.
- R9: Read offset 0 returns {request[3:0], tc[3:0]} and offset 1 returns the mask in bits [3:0] with zeros above. Other offsets read 8'h00. A status read with rd_en high clears the tc bits at the end of that cycle and keeps the request bits.
- R10: dreq_set[i] sets request bit i and dreq_clr[i] clears it; clear wins over set. Both win over a software request write to the same channel in the same cycle.
- R11: tc_in[i] sets tc bit i. A tc_in pulse in the same cycle as a clearing status read is kept.
- R12: A channel is eligible when its mask bit is 0 and its request bit is 1. The lowest eligible index gets a one-hot grant, with grant_valid high and grant_idx its number. With none eligible the grant is all zero.
- R13: A register change made by a write takes effect at the clock edge that ends the write cycle. It is not visible before that edge. The grant follows the registered state in the same cycle without further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control write strobe |
| wr_off | input | 3 | Control write offset |
| wr_data | input | 8 | Control write data |
| rd_en | input | 1 | Read strobe; with offset 0 clears tc bits |
| rd_off | input | 3 | Read offset |
| rd_data | output | 8 | Read data, combinational on rd_off |
| ff_toggle | input | 1 | Byte-pointer flip-flop toggle from channel register accesses |
| ff_q | output | 1 | Byte-pointer flip-flop state |
| cmd_q | output | 8 | Accepted command byte |
| dreq_set | input | 4 | Per-channel request assert |
| dreq_clr | input | 4 | Per-channel request release |
| tc_in | input | 4 | Per-channel terminal-count report |
| mode_q | output | 32 | All mode bytes, channel i in bits [8i+7:8i] |
| grant | output | 4 | One-hot service grant |
| grant_valid | output | 1 | A channel is granted |
| grant_idx | output | 2 | Index of the granted channel |
| grant_xfer | output | 2 | Transfer type of the granted channel |
| grant_autoinit | output | 1 | Auto-init flag of the granted channel |
| grant_decr | output | 1 | Address-decrement flag of the granted channel |
| grant_opmode | output | 2 | Operating mode of the granted channel |

## Verification
Every register effect of a write, a request input, a tc report or a clearing read is due one clock edge after the cycle that carries it. The read data and the grant follow the registers combinationally in that same following cycle. The bench drives each stimulus on a falling edge and lets exactly one rising edge pass. It then samples on the next falling edge, before new stimulus is applied. One directed check also samples before the edge, to confirm that a write has not yet taken effect. The clearing read is checked both during its own cycle, where the old tc bits must still be shown, and in the cycle after it.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

   // Control write offsets; the position of each one is decoded by the host side
   typedef enum logic [2:0] {
      WO_CMD     = 3'd0,
      WO_SWREQ   = 3'd1,
      WO_MASK1   = 3'd2,
      WO_MODE    = 3'd3,
      WO_FFCLR   = 3'd4,
      WO_MRST    = 3'd5,
      WO_UNMASK  = 3'd6,
      WO_MASKALL = 3'd7
   } wr_off_e;

   localparam logic [2:0] RO_STATUS = 3'd0;
   localparam logic [2:0] RO_MASK   = 3'd1;

   // Only this command bit may be set in an accepted command byte
   localparam logic [7:0] CMD_ALLOWED = 8'h04;

   // Bit position of the set/clear flag in request and single-mask writes
   localparam int FLAG_BIT = 2;

   // Mode byte layout (MSB first)
   typedef struct packed {
      logic [1:0] opmode;
      logic       decr;
      logic       autoinit;
      logic [1:0] xfer;
      logic [1:0] sel;
   } mode_t;

   // One strobe per write offset; bit k belongs to offset k
   typedef struct packed {
      logic maskall;
      logic unmask;
      logic mrst;
      logic ffclr;
      logic mode;
      logic mask1;
      logic swreq;
      logic cmd;
   } wstb_t;

endpackage

// File: rtl/dma_wr_decode.sv
module dma_wr_decode
   import dma_ctl_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_off,
   input  logic [DW-1:0] wr_data,
   input  logic          ff_toggle,
   output wstb_t         stb,
   output logic [DW-1:0] cmd_q,
   output logic          ff_q
);

   localparam logic [DW-1:0] CMD_OK_BITS = DW'(CMD_ALLOWED);

   logic cmd_ok;

   always_comb begin
      stb = wr_en ? wstb_t'(8'b1 << wr_off) : '0;
   end

   assign cmd_ok = (wr_data & ~CMD_OK_BITS) == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (stb.mrst) begin
         cmd_q <= '0;
      end else if (stb.cmd && cmd_ok) begin
         cmd_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ff_q <= 1'b0;
      end else if (stb.mrst || stb.ffclr) begin
         ff_q <= 1'b0;
      end else if (ff_toggle) begin
         ff_q <= ~ff_q;
      end
   end

   assert_cmd_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_off == WO_CMD && (wr_data & ~CMD_OK_BITS) != '0) |=> $stable(cmd_q))
      else $error("rejected command changed the command byte");

   assert_ff_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_off == WO_FFCLR || wr_off == WO_MRST)) |=> !ff_q)
      else $error("flip-flop not cleared");

endmodule

// File: rtl/dma_stat_mask.sv
module dma_stat_mask
   import dma_ctl_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int DW   = 8,
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            s_swreq,
   input  logic            s_mask1,
   input  logic            s_mrst,
   input  logic            s_unmask,
   input  logic            s_maskall,
   input  logic [CH_W-1:0] wr_sel,
   input  logic            wr_flag,
   input  logic [NCH-1:0]  wr_mask,
   input  logic            rd_en,
   input  logic [2:0]      rd_off,
   input  logic [NCH-1:0]  dreq_set,
   input  logic [NCH-1:0]  dreq_clr,
   input  logic [NCH-1:0]  tc_in,
   output logic [NCH-1:0]  mask_q,
   output logic [NCH-1:0]  req_q,
   output logic [NCH-1:0]  tc_q,
   output logic [DW-1:0]   rd_data
);

   logic [NCH-1:0] mask_d, req_d, tc_d;
   logic           rd_clear;

   assign rd_clear = rd_en && (rd_off == RO_STATUS);

   always_comb begin
      mask_d = mask_q;
      if (s_mrst) begin
         mask_d = '1;
      end else if (s_maskall) begin
         mask_d = wr_mask;
      end else if (s_unmask) begin
         mask_d = '0;
      end else if (s_mask1) begin
         mask_d[wr_sel] = wr_flag;
      end
   end

   always_comb begin
      req_d = req_q;
      tc_d  = tc_q;
      if (rd_clear) begin
         tc_d = '0;
      end
      if (s_swreq) begin
         req_d[wr_sel] = wr_flag;
         tc_d[wr_sel]  = 1'b0;
      end
      req_d = (req_d | dreq_set) & ~dreq_clr;
      tc_d  = tc_d | tc_in;
      if (s_mrst) begin
         req_d = '0;
         tc_d  = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         req_q  <= '0;
         tc_q   <= '0;
      end else begin
         mask_q <= mask_d;
         req_q  <= req_d;
         tc_q   <= tc_d;
      end
   end

   always_comb begin
      case (rd_off)
         RO_STATUS: rd_data = DW'({req_q, tc_q});
         RO_MASK:   rd_data = DW'(mask_q);
         default:   rd_data = '0;
      endcase
   end

   assert_rd_clears_tc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clear && tc_in == '0 && !s_swreq) |=> (tc_q == '0 && req_q == $past(req_d)))
      else $error("status read did not clear tc bits only");

   assert_dreq_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq_clr != '0) |=> ((req_q & $past(dreq_clr)) == '0))
      else $error("released request still set");

   assert_tc_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_in != '0 && !s_mrst) |=> ((tc_q & $past(tc_in)) == $past(tc_in)))
      else $error("terminal count report lost");

   assert_master_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      s_mrst |=> (mask_q == '1 && req_q == '0 && tc_q == '0))
      else $error("master reset state wrong");

endmodule

// File: rtl/dma_mode_bank.sv
module dma_mode_bank
   import dma_ctl_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int DW   = 8,
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            s_mode,
   input  logic [DW-1:0]   wr_data,
   input  logic [CH_W-1:0] sel_idx,
   output logic [NCH*DW-1:0] mode_flat,
   output mode_t           sel_mode
);

   logic [DW-1:0] mode_r [NCH];

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_r[i] <= '0;
         end else if (s_mode && wr_data[CH_W-1:0] == CH_W'(i)) begin
            mode_r[i] <= wr_data;
         end
      end

      assign mode_flat[i*DW +: DW] = mode_r[i];

      assert_mode_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (s_mode && wr_data[CH_W-1:0] == CH_W'(i)) |=> mode_r[i] == $past(wr_data))
         else $error("mode byte not stored");
   end

   assign sel_mode = mode_t'(mode_r[sel_idx][7:0]);

endmodule

// File: rtl/dma_svc_arb.sv
module dma_svc_arb #(
   parameter int NCH       = 4,
   parameter int CH_W      = 2,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCH-1:0]  mask,
   input  logic [NCH-1:0]  req,
   output logic [NCH-1:0]  grant,
   output logic            grant_valid,
   output logic [CH_W-1:0] grant_idx
);

   logic [NCH-1:0] elig;
   assign elig = req & ~mask;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         grant     = '0;
         grant_idx = '0;
         for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) begin
               grant     = NCH'(1) << i;
               grant_idx = CH_W'(i);
            end
         end
      end
   end else begin : g_high
      always_comb begin
         grant     = '0;
         grant_idx = '0;
         for (int i = 0; i < NCH; i++) begin
            if (elig[i]) begin
               grant     = NCH'(1) << i;
               grant_idx = CH_W'(i);
            end
         end
      end
   end

   assign grant_valid = |grant;

   assert_grant_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant))
      else $error("grant not one-hot");

   assert_grant_eligible_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & (mask | ~req)) == '0) && (grant_valid == (elig != '0)))
      else $error("grant to ineligible channel or missed grant");

   if (LOW_FIRST) begin : g_chk
      assert_grant_lowest_R12: assert property (@(posedge clk) disable iff (!rst_n)
         grant_valid |-> ((elig & (grant - NCH'(1))) == '0))
         else $error("lower eligible channel skipped");
   end

endmodule

// File: rtl/dma_ctl_unit.sv
module dma_ctl_unit
   import dma_ctl_pkg::*;
#(
   parameter int  NCH       = 4,
   parameter int  DW        = 8,
   parameter bit  LOW_FIRST = 1'b1,
   localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_off,
   input  logic [DW-1:0]     wr_data,
   input  logic              rd_en,
   input  logic [2:0]        rd_off,
   output logic [DW-1:0]     rd_data,
   input  logic              ff_toggle,
   output logic              ff_q,
   output logic [DW-1:0]     cmd_q,
   input  logic [NCH-1:0]    dreq_set,
   input  logic [NCH-1:0]    dreq_clr,
   input  logic [NCH-1:0]    tc_in,
   output logic [NCH*DW-1:0] mode_q,
   output logic [NCH-1:0]    grant,
   output logic              grant_valid,
   output logic [CH_W-1:0]   grant_idx,
   output logic [1:0]        grant_xfer,
   output logic              grant_autoinit,
   output logic              grant_decr,
   output logic [1:0]        grant_opmode
);

   if (DW < 8) begin : g_bad_dw
      $error("DW must be at least 8 to hold a mode byte");
   end
   if (2 * NCH > DW) begin : g_bad_nch
      $error("status byte cannot hold request and tc bits for NCH channels");
   end
   if (NCH < 2 || (NCH & (NCH - 1)) != 0 || CH_W > FLAG_BIT) begin : g_bad_pow
      $error("NCH must be a power of two from 2 to 4");
   end

   wstb_t          stb;
   logic [NCH-1:0] mask_q, req_q, tc_q;
   mode_t          gmode;

   dma_wr_decode #(.DW(DW)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_off    (wr_off),
      .wr_data   (wr_data),
      .ff_toggle (ff_toggle),
      .stb       (stb),
      .cmd_q     (cmd_q),
      .ff_q      (ff_q)
   );

   dma_stat_mask #(.NCH(NCH), .DW(DW), .CH_W(CH_W)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_swreq   (stb.swreq),
      .s_mask1   (stb.mask1),
      .s_mrst    (stb.mrst),
      .s_unmask  (stb.unmask),
      .s_maskall (stb.maskall),
      .wr_sel    (wr_data[CH_W-1:0]),
      .wr_flag   (wr_data[FLAG_BIT]),
      .wr_mask   (wr_data[NCH-1:0]),
      .rd_en     (rd_en),
      .rd_off    (rd_off),
      .dreq_set  (dreq_set),
      .dreq_clr  (dreq_clr),
      .tc_in     (tc_in),
      .mask_q    (mask_q),
      .req_q     (req_q),
      .tc_q      (tc_q),
      .rd_data   (rd_data)
   );

   dma_mode_bank #(.NCH(NCH), .DW(DW), .CH_W(CH_W)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_mode    (stb.mode),
      .wr_data   (wr_data),
      .sel_idx   (grant_idx),
      .mode_flat (mode_q),
      .sel_mode  (gmode)
   );

   dma_svc_arb #(.NCH(NCH), .CH_W(CH_W), .LOW_FIRST(LOW_FIRST)) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .mask        (mask_q),
      .req         (req_q),
      .grant       (grant),
      .grant_valid (grant_valid),
      .grant_idx   (grant_idx)
   );

   assign grant_xfer     = gmode.xfer;
   assign grant_autoinit = gmode.autoinit;
   assign grant_decr     = gmode.decr;
   assign grant_opmode   = gmode.opmode;

   assert_single_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_off == WO_MASK1) |=>
         (mask_q[$past(wr_data[CH_W-1:0])] == $past(wr_data[FLAG_BIT])))
      else $error("single mask write not applied");

   assert_write_edge_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && dreq_set == '0 && dreq_clr == '0 && tc_in == '0 && !rd_en) |=>
         ($stable(mask_q) && $stable(req_q) && $stable(tc_q) && $stable(cmd_q)))
      else $error("state changed without a cause");

endmodule

// File: tb/dma_ctl_unit_tb.sv
`timescale 1ns/1ps
module dma_ctl_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_off = '0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_off = '0;
   logic [7:0]  rd_data;
   logic        ff_toggle = 1'b0;
   logic        ff_q;
   logic [7:0]  cmd_q;
   logic [3:0]  dreq_set = '0;
   logic [3:0]  dreq_clr = '0;
   logic [3:0]  tc_in = '0;
   logic [31:0] mode_q;
   logic [3:0]  grant;
   logic        grant_valid;
   logic [1:0]  grant_idx;
   logic [1:0]  grant_xfer;
   logic        grant_autoinit;
   logic        grant_decr;
   logic [1:0]  grant_opmode;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dma_ctl_unit u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
      .rd_en(rd_en), .rd_off(rd_off), .rd_data(rd_data), .ff_toggle(ff_toggle),
      .ff_q(ff_q), .cmd_q(cmd_q), .dreq_set(dreq_set), .dreq_clr(dreq_clr),
      .tc_in(tc_in), .mode_q(mode_q), .grant(grant), .grant_valid(grant_valid),
      .grant_idx(grant_idx), .grant_xfer(grant_xfer), .grant_autoinit(grant_autoinit),
      .grant_decr(grant_decr), .grant_opmode(grant_opmode)
   );

   // {pad, wr_en, wr_off, wr_data, dreq_set, peek_off, exp_rd, exp_grant}
   localparam int NV = 14;
   localparam logic [31:0] TBL [NV] = '{
      {1'b0, 1'b1, 3'd6, 8'h00, 4'h0, 3'd1, 8'h00, 4'h0},
      {1'b0, 1'b1, 3'd1, 8'h05, 4'h0, 3'd0, 8'h20, 4'h2},
      {1'b0, 1'b1, 3'd1, 8'h04, 4'h0, 3'd0, 8'h30, 4'h1},
      {1'b0, 1'b1, 3'd2, 8'h04, 4'h0, 3'd1, 8'h01, 4'h2},
      {1'b0, 1'b1, 3'd7, 8'h0E, 4'h0, 3'd1, 8'h0E, 4'h1},
      {1'b0, 1'b0, 3'd0, 8'h00, 4'h8, 3'd0, 8'hB0, 4'h1},
      {1'b0, 1'b1, 3'd1, 8'h00, 4'h0, 3'd0, 8'hA0, 4'h0},
      {1'b0, 1'b1, 3'd3, 8'h94, 4'h0, 3'd3, 8'h00, 4'h0},
      {1'b0, 1'b1, 3'd6, 8'h00, 4'h0, 3'd1, 8'h00, 4'h2},
      {1'b0, 1'b1, 3'd2, 8'h05, 4'h0, 3'd1, 8'h02, 4'h8},
      {1'b0, 1'b1, 3'd2, 8'h01, 4'h0, 3'd1, 8'h00, 4'h2},
      {1'b0, 1'b1, 3'd5, 8'h00, 4'h0, 3'd0, 8'h00, 4'h0},
      {1'b0, 1'b0, 3'd0, 8'h00, 4'h0, 3'd1, 8'h0F, 4'h0},
      {1'b0, 1'b0, 3'd0, 8'h00, 4'h0, 3'd5, 8'h00, 4'h0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] off, input logic [7:0] d);
      wr_en = 1'b1; wr_off = off; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic peek(input logic [2:0] off, input string tag, input logic [7:0] exp);
      rd_off = off;
      #0.1;
      check(tag, rd_data, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      peek(3'd1, "R1 mask", 8'h0F);
      peek(3'd0, "R1 status", 8'h00);
      check("R1 cmd", cmd_q, 8'h00);
      check("R1 ff", ff_q, 1'b0);
      check("R1 modes", mode_q, 32'h0);
      check("R1 grant", {grant_valid, grant}, 5'h0);
      rst_n = 1'b1;
      step();

      // Table walk: R3 R4 R5 R9 R10 R12
      for (int i = 0; i < NV; i++) begin
         wr_en    = TBL[i][30];
         wr_off   = TBL[i][29:27];
         wr_data  = TBL[i][26:19];
         dreq_set = TBL[i][18:15];
         rd_off   = TBL[i][14:12];
         step();
         wr_en = 1'b0; dreq_set = '0;
         check($sformatf("R3/R4/R5/R9/R10 table rd %0d", i), rd_data, TBL[i][11:4]);
         check($sformatf("R12 table grant %0d", i), grant, TBL[i][3:0]);
      end

      // R7 master reset keeps mode bytes
      check("R7 mode kept", mode_q[7:0], 8'h94);

      // R2 command acceptance
      wr(3'd0, 8'h04); check("R2 accept 04", cmd_q, 8'h04);
      wr(3'd0, 8'h01); check("R2 reject 01", cmd_q, 8'h04);
      wr(3'd0, 8'h00); check("R2 accept 00", cmd_q, 8'h00);
      wr(3'd0, 8'h05); check("R2 reject 05", cmd_q, 8'h00);

      // R8 flip-flop
      ff_toggle = 1'b1; step(); ff_toggle = 1'b0;
      check("R8 toggle", ff_q, 1'b1);
      wr(3'd4, 8'h00); check("R8 clear", ff_q, 1'b0);
      ff_toggle = 1'b1; wr_en = 1'b1; wr_off = 3'd4; step();
      ff_toggle = 1'b0; wr_en = 1'b0;
      check("R8 clear wins", ff_q, 1'b0);
      ff_toggle = 1'b1; step(); ff_toggle = 1'b0;
      wr(3'd0, 8'h04);
      wr(3'd5, 8'h00);
      check("R7 ff cleared", ff_q, 1'b0);
      check("R7 cmd cleared", cmd_q, 8'h00);

      // R6 mode fields of granted channel
      wr(3'd6, 8'h00);
      dreq_set = 4'h4; step(); dreq_set = '0;
      wr(3'd3, 8'h96);
      check("R6 grant", {grant_valid, grant_idx, grant}, {1'b1, 2'd2, 4'h4});
      check("R6 fields", {grant_xfer, grant_autoinit, grant_decr, grant_opmode},
            {2'b01, 1'b1, 1'b0, 2'b10});
      check("R6 byte", mode_q[23:16], 8'h96);

      // R11 / R9 terminal count and clearing read
      tc_in = 4'h4; step(); tc_in = '0;
      peek(3'd0, "R11 tc set", 8'h44);
      rd_en = 1'b1; rd_off = 3'd0; #0.1;
      check("R9 read shows tc", rd_data, 8'h44);
      step(); rd_en = 1'b0;
      peek(3'd0, "R9 tc cleared req kept", 8'h40);
      tc_in = 4'h4; rd_en = 1'b1; step(); tc_in = '0; rd_en = 1'b0;
      peek(3'd0, "R11 tc survives read", 8'h44);

      // R3 request write clears tc of its channel
      wr(3'd1, 8'h06);
      peek(3'd0, "R3 tc cleared", 8'h40);

      // R10 external request precedence
      dreq_set = 4'h2; dreq_clr = 4'h2; step(); dreq_set = '0; dreq_clr = '0;
      peek(3'd0, "R10 clear wins", 8'h40);
      dreq_set = 4'h2; wr(3'd1, 8'h01); dreq_set = '0;
      peek(3'd0, "R10 over software", 8'h60);
      dreq_clr = 4'h4; step(); dreq_clr = '0;
      peek(3'd0, "R10 release", 8'h20);
      check("R12 after release", {grant_idx, grant}, {2'd1, 4'h2});

      // R13 write not visible before the edge
      wr_en = 1'b1; wr_off = 3'd2; wr_data = 8'h05;
      peek(3'd1, "R13 before edge", 8'h00);
      step(); wr_en = 1'b0;
      peek(3'd1, "R13 after edge", 8'h02);
      check("R13 grant follows", grant, 4'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule